// File: doc/BRIEF.md
# Four-Beat Double-Rate Burst Gearbox

This block sits between a double-data-rate external data path and an internal memory with separate read and write ports, each one word wide, where a word holds four beats. The pad logic delivers two beats per clock cycle: the beat captured on the rising edge and the beat captured on the falling edge. On a write burst the block takes two such beat pairs on consecutive cycles, steers each beat into its lane of a wide holding word together with its byte-enable bits, and then issues one internal write of the whole word and its mask. On a read burst it sends the word address to the array, catches the returned word, and plays it back as two beat pairs on consecutive cycles.

A mode input picks the order in which beats map to lanes. In wrap mode the two low address bits give the lane of the first beat, and the following beats take the next lanes in ascending order, wrapping from lane 3 to lane 0. In fixed mode beat k always uses lane k, and the two low address bits are dropped. The mode and the low address bits are sampled only in the cycle that starts a burst. Bursts on either path may follow each other with no idle cycle, and reads and writes run independently of each other.

Top module: `ddr_burst4_gearbox`

## Requirements
- R1: While reset is asserted and after its release with no burst started, memWrEn and rdValid are 0 and rdRise and rdFall are 0.
- R2: In fixed mode a write burst started in cycle N (wrStart high, beats 0 and 1 on wrRise and wrFall) and continued in cycle N+1 (beats 2 and 3) gives memWrEn high for exactly cycle N+2, with beat k in lane k of memWrData, where lane j occupies bits [8j+7:8j].
- R3: In wrap mode, with low address bits A = wrAddr[1:0] at the start, write beat k lands in lane (A+k) mod 4; changes to cwfMode or wrAddr in the second cycle of the burst have no effect.
- R4: In fixed mode wrAddr[1:0] and rdAddr[1:0] are ignored: the lane order is the same for every value of these bits.
- R5: memWrAddr equals wrAddr[ADDR_W-1:2] as sampled in the start cycle of the write burst.
- R6: The byte-enable bits of each write beat are gathered into memWrMask in the same lane as that beat's data (lane j of the mask at bit j for one enable bit per beat).
- R7: A read burst started in cycle N drives memRdEn high in cycle N with memRdAddr equal to rdAddr[ADDR_W-1:2]; the array returns the word on memRdData in cycle N+1.
- R8: In fixed mode a read started in cycle N gives rdValid high in cycles N+2 and N+3, with lanes 0 and 1 on rdRise and rdFall in N+2 and lanes 2 and 3 in N+3.
- R9: In wrap mode, read beat k is taken from lane (A+k) mod 4 of the returned word, with A = rdAddr[1:0] at the start; a mode change in the second cycle has no effect.
- R10: A new burst may start in the cycle right after the second cycle of the previous one on either path, and each burst still gives its own results on the timing of R2 and R8; reads and writes may run in the same cycles.
- R11: rdRise and rdFall are 0 in every cycle where rdValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cwfMode | input | 1 | 1: wrap order from low address bits, 0: fixed order |
| wrStart | input | 1 | First cycle of a write burst |
| wrAddr | input | ADDR_W | Write beat address, sampled with wrStart |
| wrRise | input | BEAT_W | Write beat from the rising edge (beat 0, then beat 2) |
| wrFall | input | BEAT_W | Write beat from the falling edge (beat 1, then beat 3) |
| wrMaskRise | input | MASK_W | Byte enables of the rising-edge write beat |
| wrMaskFall | input | MASK_W | Byte enables of the falling-edge write beat |
| rdStart | input | 1 | First cycle of a read burst |
| rdAddr | input | ADDR_W | Read beat address, sampled with rdStart |
| rdValid | output | 1 | Read beat pair is on rdRise and rdFall |
| rdRise | output | BEAT_W | Read beat for the rising edge |
| rdFall | output | BEAT_W | Read beat for the falling edge |
| memWrEn | output | 1 | One-cycle internal write strobe |
| memWrAddr | output | ADDR_W-2 | Internal write word address |
| memWrData | output | 4*BEAT_W | Gathered write word |
| memWrMask | output | 4*MASK_W | Gathered write byte enables |
| memRdEn | output | 1 | Internal read strobe |
| memRdAddr | output | ADDR_W-2 | Internal read word address |
| memRdData | input | 4*BEAT_W | Word returned by the array one cycle after memRdEn |

## Verification
The assertions watch, on every cycle, that each write start is followed two cycles later by a single-cycle write strobe, that each read start opens a two-cycle output window two cycles later, that no start lands in the second cycle of a burst on the same path, that fixed mode never presets a lane offset, and that the read outputs stay at zero outside the window. Which lane each beat reaches, the gathered mask, the word addresses and the immunity to mode and address changes in the second cycle can only be shown by the bench's sweeps over both modes and all four starting lanes, with gaps, back to back, and with reads and writes overlapping.

// File: rtl/burst4_pkg.sv
package burst4_pkg;

  localparam int LANES = 4;

  typedef logic [1:0] lane_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic  wrFirst;  // first beat pair of a write burst
    logic  wrLast;   // second beat pair of a write burst
    lane_t wrBase;   // lane of write beat 0
    logic  rdLoad;   // returned word is on memRdData
    lane_t rdBase;   // lane of read beat 0
    logic  rdShow;   // a read beat pair is driven out
    logic  rdHalf;   // 0: beats 0/1, 1: beats 2/3
  } laneCtl_t;

endpackage

// File: rtl/burst4_ctrl.sv
module burst4_ctrl
  import burst4_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cwfMode,
  input  logic     wrStart,
  input  lane_t    wrLow,
  input  logic     rdStart,
  input  lane_t    rdLow,
  output laneCtl_t ctl,
  output logic     memWrEn,
  output logic     rdValid
);

  logic  wrTail;
  logic  wrCommit;
  lane_t wrBaseQ;
  lane_t wrBaseNow;
  logic  rdLoadQ;
  lane_t rdBaseQ;
  lane_t rdBaseNow;
  logic  rdShowA;
  logic  rdShowB;

  assign wrBaseNow = cwfMode ? wrLow : lane_t'(0);
  assign rdBaseNow = cwfMode ? rdLow : lane_t'(0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrTail   <= 1'b0;
      wrCommit <= 1'b0;
      wrBaseQ  <= '0;
    end else begin
      wrTail   <= wrStart;
      wrCommit <= wrTail;
      if (wrStart) wrBaseQ <= wrBaseNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdLoadQ <= 1'b0;
      rdBaseQ <= '0;
      rdShowA <= 1'b0;
      rdShowB <= 1'b0;
    end else begin
      rdLoadQ <= rdStart;
      rdShowA <= rdLoadQ;
      rdShowB <= rdShowA;
      if (rdStart) rdBaseQ <= rdBaseNow;
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.wrFirst = wrStart;
    ctl.wrLast  = wrTail;
    ctl.wrBase  = wrStart ? wrBaseNow : wrBaseQ;
    ctl.rdLoad  = rdLoadQ;
    ctl.rdBase  = rdBaseQ;
    ctl.rdShow  = rdShowA | rdShowB;
    ctl.rdHalf  = rdShowB;
  end

  assign memWrEn = wrCommit;
  assign rdValid = rdShowA | rdShowB;

  // R2
  wr_commit_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStart |-> ##2 memWrEn);

  // R10
  wr_commit_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> !memWrEn);

  // R10
  wr_no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrTail |-> !wrStart);

  // R10
  rd_no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdLoadQ |-> !rdStart);

  // R8
  rd_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdStart |-> ##2 rdValid ##1 rdValid);

  // R4
  fixed_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStart && !cwfMode) |=> (wrBaseQ == 2'd0));

endmodule

// File: rtl/burst4_dpath.sv
module burst4_dpath
  import burst4_pkg::*;
#(
  parameter int BEAT_W  = 8,
  parameter int MASK_W  = 1,
  parameter int WADDR_W = 8,
  localparam int WORD_W = LANES * BEAT_W,
  localparam int WMSK_W = LANES * MASK_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  laneCtl_t           ctl,
  input  logic [WADDR_W-1:0] wrAddrHi,
  input  logic [BEAT_W-1:0]  wrRise,
  input  logic [BEAT_W-1:0]  wrFall,
  input  logic [MASK_W-1:0]  wrMaskRise,
  input  logic [MASK_W-1:0]  wrMaskFall,
  input  logic [WORD_W-1:0]  memRdData,
  output logic [WADDR_W-1:0] memWrAddr,
  output logic [WORD_W-1:0]  memWrData,
  output logic [WMSK_W-1:0]  memWrMask,
  output logic [BEAT_W-1:0]  rdRise,
  output logic [BEAT_W-1:0]  rdFall
);

  logic [BEAT_W-1:0] sBeat [LANES];
  logic [WADDR_W-1:0] wAddrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wAddrQ <= '0;
    else if (ctl.wrFirst) wAddrQ <= wrAddrHi;
  end
  assign memWrAddr = wAddrQ;

  // gather: each lane picks the beat whose offset from the base it holds
  for (genvar g = 0; g < LANES; g++) begin : gGather
    lane_t             off;
    logic [BEAT_W-1:0] gData;
    logic [MASK_W-1:0] gMask;

    assign off = lane_t'(g) - ctl.wrBase;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        gData <= '0;
        gMask <= '0;
      end else if (ctl.wrFirst && off == 2'd0) begin
        gData <= wrRise;
        gMask <= wrMaskRise;
      end else if (ctl.wrFirst && off == 2'd1) begin
        gData <= wrFall;
        gMask <= wrMaskFall;
      end else if (ctl.wrLast && off == 2'd2) begin
        gData <= wrRise;
        gMask <= wrMaskRise;
      end else if (ctl.wrLast && off == 2'd3) begin
        gData <= wrFall;
        gMask <= wrMaskFall;
      end
    end

    assign memWrData[g*BEAT_W +: BEAT_W] = gData;
    assign memWrMask[g*MASK_W +: MASK_W] = gMask;
  end

  // scatter: beat slot k is filled from lane base+k of the returned word
  for (genvar k = 0; k < LANES; k++) begin : gScatter
    lane_t src;
    assign src = lane_t'(k) + ctl.rdBase;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sBeat[k] <= '0;
      else if (ctl.rdLoad) sBeat[k] <= memRdData[int'(src)*BEAT_W +: BEAT_W];
    end
  end

  always_comb begin
    rdRise = '0;
    rdFall = '0;
    if (ctl.rdShow) begin
      rdRise = ctl.rdHalf ? sBeat[2] : sBeat[0];
      rdFall = ctl.rdHalf ? sBeat[3] : sBeat[1];
    end
  end

endmodule

// File: rtl/ddr_burst4_gearbox.sv
module ddr_burst4_gearbox
  import burst4_pkg::*;
#(
  parameter int BEAT_W = 8,
  parameter int MASK_W = 1,
  parameter int ADDR_W = 10,
  localparam int WADDR_W = ADDR_W - 2,
  localparam int WORD_W  = LANES * BEAT_W,
  localparam int WMSK_W  = LANES * MASK_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cwfMode,
  input  logic               wrStart,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [BEAT_W-1:0]  wrRise,
  input  logic [BEAT_W-1:0]  wrFall,
  input  logic [MASK_W-1:0]  wrMaskRise,
  input  logic [MASK_W-1:0]  wrMaskFall,
  input  logic               rdStart,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic               rdValid,
  output logic [BEAT_W-1:0]  rdRise,
  output logic [BEAT_W-1:0]  rdFall,
  output logic               memWrEn,
  output logic [WADDR_W-1:0] memWrAddr,
  output logic [WORD_W-1:0]  memWrData,
  output logic [WMSK_W-1:0]  memWrMask,
  output logic               memRdEn,
  output logic [WADDR_W-1:0] memRdAddr,
  input  logic [WORD_W-1:0]  memRdData
);

  laneCtl_t ctl;

  burst4_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .cwfMode (cwfMode),
    .wrStart (wrStart),
    .wrLow   (wrAddr[1:0]),
    .rdStart (rdStart),
    .rdLow   (rdAddr[1:0]),
    .ctl     (ctl),
    .memWrEn (memWrEn),
    .rdValid (rdValid)
  );

  burst4_dpath #(
    .BEAT_W  (BEAT_W),
    .MASK_W  (MASK_W),
    .WADDR_W (WADDR_W)
  ) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .wrAddrHi   (wrAddr[ADDR_W-1:2]),
    .wrRise     (wrRise),
    .wrFall     (wrFall),
    .wrMaskRise (wrMaskRise),
    .wrMaskFall (wrMaskFall),
    .memRdData  (memRdData),
    .memWrAddr  (memWrAddr),
    .memWrData  (memWrData),
    .memWrMask  (memWrMask),
    .rdRise     (rdRise),
    .rdFall     (rdFall)
  );

  assign memRdEn   = rdStart;
  assign memRdAddr = rdAddr[ADDR_W-1:2];

  // R11
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdRise == '0 && rdFall == '0));

endmodule

// File: tb/sim_ddr_burst4_gearbox.sv
module sim_ddr_burst4_gearbox;

  localparam int BW = 8;
  localparam int MW = 1;
  localparam int AW = 10;
  localparam int QN = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cwfMode = 1'b0;
  logic        wrStart = 1'b0;
  logic [9:0]  wrAddr = '0;
  logic [7:0]  wrRise = '0;
  logic [7:0]  wrFall = '0;
  logic        wrMaskRise = 1'b0;
  logic        wrMaskFall = 1'b0;
  logic        rdStart = 1'b0;
  logic [9:0]  rdAddr = '0;
  logic        rdValid;
  logic [7:0]  rdRise;
  logic [7:0]  rdFall;
  logic        memWrEn;
  logic [7:0]  memWrAddr;
  logic [31:0] memWrData;
  logic [3:0]  memWrMask;
  logic        memRdEn;
  logic [7:0]  memRdAddr;
  logic [31:0] memRdData = '0;

  int cyc = 0;
  int nChecks = 0;
  int nFail = 0;

  int          expWrCyc  [QN];
  logic [7:0]  expWrAddr [QN];
  logic [31:0] expWrData [QN];
  logic [3:0]  expWrMask [QN];
  string       expWrTag  [QN];
  bit          expWrB2b  [QN];
  int wrPush = 0;
  int wrPop  = 0;

  int          expRdCyc   [QN];
  logic [7:0]  expRdAddr  [QN];
  logic [31:0] expRdBeats [QN];
  string       expRdTag   [QN];
  bit          expRdB2b   [QN];
  int rdPush  = 0;
  int rdPop   = 0;
  int rdIssue = 0;

  ddr_burst4_gearbox #(.BEAT_W(BW), .MASK_W(MW), .ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .cwfMode(cwfMode),
    .wrStart(wrStart), .wrAddr(wrAddr), .wrRise(wrRise), .wrFall(wrFall),
    .wrMaskRise(wrMaskRise), .wrMaskFall(wrMaskFall),
    .rdStart(rdStart), .rdAddr(rdAddr), .rdValid(rdValid),
    .rdRise(rdRise), .rdFall(rdFall),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .memWrMask(memWrMask), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .memRdData(memRdData)
  );

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] wordFn(input logic [7:0] w);
    logic [31:0] r;
    for (int j = 0; j < 4; j++) r[j*8 +: 8] = 8'(int'(w) * 7 + j * 29 + 11);
    return r;
  endfunction

  // array model: one-cycle read latency
  always @(posedge clk) if (memRdEn) memRdData <= wordFn(memRdAddr);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  function automatic int laneOf(input bit mode, input int a, input int k);
    return mode ? (a + k) % 4 : k;
  endfunction

  task automatic wrBurst(input bit mode, input int a, input logic [7:0] word,
                         input int tag, input bit flip, input bit b2b);
    logic [7:0]  b [4];
    logic        m [4];
    logic [31:0] d;
    logic [3:0]  mk;
    for (int k = 0; k < 4; k++) begin
      b[k] = 8'(tag * 13 + k * 5 + 3);
      m[k] = 1'((tag + k) % 3 != 0);
      d[laneOf(mode, a, k)*8 +: 8] = b[k];
      mk[laneOf(mode, a, k)] = m[k];
    end
    @(posedge clk); #1;
    cwfMode = mode; wrStart = 1'b1; wrAddr = {word, 2'(a)};
    wrRise = b[0]; wrFall = b[1]; wrMaskRise = m[0]; wrMaskFall = m[1];
    expWrCyc[wrPush]  = cyc;
    expWrAddr[wrPush] = word;
    expWrData[wrPush] = d;
    expWrMask[wrPush] = mk;
    expWrTag[wrPush]  = mode ? "R3" : (a == 0 ? "R2" : "R4");
    expWrB2b[wrPush]  = b2b;
    wrPush++;
    @(posedge clk); #1;
    wrStart = 1'b0;
    wrRise = b[2]; wrFall = b[3]; wrMaskRise = m[2]; wrMaskFall = m[3];
    if (flip) begin
      cwfMode = ~mode;
      wrAddr  = ~wrAddr;
    end
  endtask

  task automatic rdBurst(input bit mode, input int a, input logic [7:0] word,
                         input bit flip, input bit b2b);
    logic [31:0] w;
    logic [31:0] e;
    w = wordFn(word);
    for (int k = 0; k < 4; k++) e[k*8 +: 8] = w[laneOf(mode, a, k)*8 +: 8];
    @(posedge clk); #1;
    cwfMode = mode; rdStart = 1'b1; rdAddr = {word, 2'(a)};
    expRdCyc[rdPush]   = cyc;
    expRdAddr[rdPush]  = word;
    expRdBeats[rdPush] = e;
    expRdTag[rdPush]   = mode ? "R9" : (a == 0 ? "R8" : "R4");
    expRdB2b[rdPush]   = b2b;
    rdPush++;
    @(posedge clk); #1;
    rdStart = 1'b0;
    if (flip) begin
      cwfMode = ~mode;
      rdAddr  = ~rdAddr;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      wrStart = 1'b0; rdStart = 1'b0;
    end
  endtask

  // monitor away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (memWrEn) begin
        if (wrPop >= wrPush) check(1'b0, "R2", "unexpected write", 32'(memWrData), 32'h0);
        else begin
          check(cyc == expWrCyc[wrPop] + 2, expWrB2b[wrPop] ? "R10" : "R2",
                "write cycle", 32'(cyc), 32'(expWrCyc[wrPop] + 2));
          check(memWrData == expWrData[wrPop], expWrTag[wrPop], "write data",
                memWrData, expWrData[wrPop]);
          check(memWrAddr == expWrAddr[wrPop], "R5", "write addr",
                32'(memWrAddr), 32'(expWrAddr[wrPop]));
          check(memWrMask == expWrMask[wrPop], "R6", "write mask",
                32'(memWrMask), 32'(expWrMask[wrPop]));
          wrPop++;
        end
      end
      if (memRdEn) begin
        if (rdIssue >= rdPush) check(1'b0, "R7", "unexpected read", 32'(memRdAddr), 32'h0);
        else begin
          check(cyc == expRdCyc[rdIssue], "R7", "read issue cycle",
                32'(cyc), 32'(expRdCyc[rdIssue]));
          check(memRdAddr == expRdAddr[rdIssue], "R7", "read addr",
                32'(memRdAddr), 32'(expRdAddr[rdIssue]));
          rdIssue++;
        end
      end
      if (rdValid) begin
        if (rdPop >= rdPush) check(1'b0, "R8", "unexpected beats", 32'(rdRise), 32'h0);
        else if (cyc == expRdCyc[rdPop] + 2) begin
          check({rdFall, rdRise} == expRdBeats[rdPop][15:0], expRdTag[rdPop],
                "beats 0/1", 32'({rdFall, rdRise}), 32'(expRdBeats[rdPop][15:0]));
        end else if (cyc == expRdCyc[rdPop] + 3) begin
          check({rdFall, rdRise} == expRdBeats[rdPop][31:16], expRdTag[rdPop],
                "beats 2/3", 32'({rdFall, rdRise}), 32'(expRdBeats[rdPop][31:16]));
          rdPop++;
        end else begin
          check(1'b0, expRdB2b[rdPop] ? "R10" : "R8", "read window cycle",
                32'(cyc), 32'(expRdCyc[rdPop] + 2));
        end
      end else begin
        check(rdRise == 8'h0 && rdFall == 8'h0, "R11", "idle read beats",
              32'({rdFall, rdRise}), 32'h0);
      end
    end
  end

  initial begin
    #(4 * 150000);
    check(1'b0, "R2", "watchdog expired", 32'(cyc), 32'h0);
    finishRun();
  end

  initial begin
    int tag = 1;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    check(memWrEn == 1'b0 && rdValid == 1'b0, "R1", "reset strobes",
          32'({memWrEn, rdValid}), 32'h0);
    check(rdRise == 8'h0 && rdFall == 8'h0, "R1", "reset beats",
          32'({rdFall, rdRise}), 32'h0);
    @(posedge clk); #1; rstN = 1'b1;
    idle(2);
    @(negedge clk);
    check(memWrEn == 1'b0 && rdValid == 1'b0, "R1", "idle after reset",
          32'({memWrEn, rdValid}), 32'h0);

    // gapped bursts, both modes, all start lanes, mode/addr disturbed in cycle 2
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 4; a++) begin
        wrBurst(1'(m), a, 8'(m * 40 + a * 9 + 3), tag, 1'b1, 1'b0);
        tag++;
        idle(3);
      end
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 4; a++) begin
        rdBurst(1'(m), a, 8'(m * 50 + a * 17 + 5), 1'b1, 1'b0);
        idle(4);
      end

    // back-to-back writes then back-to-back reads (R10)
    for (int i = 0; i < 8; i++) begin
      wrBurst(1'(i % 2), (i * 3) % 4, 8'(i * 31 + 7), tag, 1'b0, 1'b1);
      tag++;
    end
    idle(4);
    for (int i = 0; i < 8; i++) rdBurst(1'(i / 4), (i * 3 + 1) % 4, 8'(i * 23 + 2), 1'b0, 1'b1);
    idle(5);

    // reads and writes overlapping, back to back (R10)
    for (int i = 0; i < 8; i++) begin
      fork
        wrBurst(1'(i % 2), i % 4, 8'(i * 11 + 100), tag, 1'b0, 1'b1);
        rdBurst(1'(i % 2), (i + 2) % 4, 8'(i * 19 + 60), 1'b0, 1'b1);
      join
      tag++;
    end
    idle(6);
    @(negedge clk);
    check(wrPop == wrPush, "R2", "writes committed", 32'(wrPop), 32'(wrPush));
    check(rdPop == rdPush, "R8", "reads returned", 32'(rdPop), 32'(rdPush));
    finishRun();
  end

endmodule